// File: doc/BRIEF.md
# IDE Channel Access Decoder

This block sits between a host I/O port and the task-file register ports of the IDE channels. A host access arrives in one cycle. It names a channel, one of two windows, a byte offset, a size code, a direction and write data. The first window is an eight-byte register window, used for the task-file registers and the data port. The second is a four-byte control window. The decoder accepts or rejects the access. An accepted access becomes a single-cycle strobe to the chosen channel's task-file port, together with a translated register address and a transfer width.

Strobe, address, width and write data are combinational from the host request, so the task-file port sees the request in the same cycle. The host always gets its read result in the following cycle from a register. That result is either the task-file read data masked to the access width, or the float pattern (all ones at the access width) when the access was rejected. A rejected write has no effect on any task-file port.

Top module: `ide_chan_decode`

## Requirements
- R1: While reset is high, and in the first cycle after it, `host_rvalid` is 0 and `host_rdata` is 0.
- R2: A byte access (`host_size` = 0) to the register window (`host_win` = 0) at any offset 0..7 is accepted. It is forwarded with `tf_addr` = {0, offset}, `tf_size` = 0, `tf_we` equal to `host_we` and `tf_wdata` equal to `host_wdata`.
- R3: A 16-bit access (`host_size` = 1) to the register window at offset 0 is accepted with `tf_addr` = 0 and `tf_size` = 1.
- R4: A 32-bit access (`host_size` = 2) to the register window at offset 0 is accepted with `tf_addr` = 0 and `tf_size` = 2.
- R5: A 16-bit or 32-bit register-window access at a nonzero offset raises no strobe. A read of it returns all ones at the access width (0x0000FFFF or 0xFFFFFFFF).
- R6: In the control window (`host_win` = 1) only offset bits [1:0] are decoded, and bit 2 is ignored. A byte access at offset 2 is the only one accepted. It is forwarded with `tf_addr` = 4'hC (bit 3 marks the control space, and the offset is raised by 2 to 4) and `tf_size` = 0.
- R7: Every other control-window access raises no strobe. A read of it returns all ones at the access width (0xFF, 0xFFFF or 0xFFFFFFFF).
- R8: Size code 3 is reserved. It is never accepted and reads back 0xFFFFFFFF.
- R9: An accepted access strobes only `tf_stb[host_chan]`. The read result comes from that channel's slice of `tf_rdata`. At most one strobe bit is high in any cycle.
- R10: `host_rvalid` is high exactly in the cycle after a read request (`host_valid` high, `host_we` low). `host_rdata` then holds the task-file read data zero-extended from the access width (8, 16 or 32 bits), or the R5/R7/R8 float value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access request this cycle |
| host_chan | input | CH_W | Channel index |
| host_win | input | 1 | 0 = register window, 1 = control window |
| host_off | input | 3 | Byte offset within the window |
| host_size | input | 2 | 0 = byte, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wdata | input | DW | Host write data |
| host_rvalid | output | 1 | Read result valid (one cycle after the read request) |
| host_rdata | output | DW | Read result |
| tf_stb | output | NUM_CH | Per-channel task-file access strobe |
| tf_we | output | 1 | Task-file write enable |
| tf_addr | output | 4 | Task-file register address (bit 3 = control space) |
| tf_size | output | 2 | Task-file transfer width code |
| tf_wdata | output | DW | Task-file write data |
| tf_rdata | input | NUM_CH*DW | Per-channel task-file read data, combinational in the strobe cycle |

## Verification
The assertions assume that `host_chan` is below NUM_CH and that each task-file port returns its read data combinationally in the strobe cycle. They also assume that the host inputs are stable across the sampling edge. The stimulus keeps the channel index within range. It drives every input half a cycle before the edge, and the stub derives read data combinationally from channel and address. Random accesses spread evenly over windows, offsets, all four size codes and both directions. Directed cases pin the control offset, its aliased bit 2 and the reserved size.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int TF_AW = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic             ok;
    logic [TF_AW-1:0] addr;
    acc_size_e        size;
  } tf_cmd_t;

  function automatic logic [31:0] float_mask(acc_size_e s);
    case (s)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/ide_acc_qualify.sv
module ide_acc_qualify
  import ide_dec_pkg::*;
#(
  parameter int OFF_W      = 3,
  parameter int CTRL_OFF   = 2,
  parameter int CTRL_SHIFT = 2
) (
  input  logic             win,
  input  logic [OFF_W-1:0] off,
  input  acc_size_e        size,
  output tf_cmd_t          cmd
);
  localparam logic [OFF_W-1:0] CTRL_FWD = OFF_W'(CTRL_OFF + CTRL_SHIFT);

  always_comb begin
    cmd      = '0;
    cmd.size = size;
    if (!win) begin
      if (size == SZ_BYTE) begin
        cmd.ok   = 1'b1;
        cmd.addr = {1'b0, off};
      end else if (size != SZ_RSVD && off == '0) begin
        cmd.ok   = 1'b1;
        cmd.addr = '0;
      end
    end else if (size == SZ_BYTE && off[1:0] == 2'(CTRL_OFF)) begin
      cmd.ok   = 1'b1;
      cmd.addr = {1'b1, CTRL_FWD};
    end
  end
endmodule

// File: rtl/ide_rd_return.sv
module ide_rd_return
  import ide_dec_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = 32,
  parameter int CH_W   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_req,
  input  logic               ok,
  input  acc_size_e          size,
  input  logic [CH_W-1:0]    chan,
  input  logic [NUM_CH*DW-1:0] tf_rdata,
  output logic               rvalid,
  output logic [DW-1:0]      rdata
);
  logic [DW-1:0] sel;
  logic [DW-1:0] mask;
  logic [DW-1:0] nxt;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chan == CH_W'(i)) sel = tf_rdata[i*DW +: DW];
    end
    mask = DW'(float_mask(size));
    nxt  = ok ? (sel & mask) : mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) rdata <= nxt;
    end
  end
endmodule

// File: rtl/ide_chan_decode.sv
module ide_chan_decode
  import ide_dec_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int DW         = 32,
  parameter int OFF_W      = 3,
  parameter int CTRL_OFF   = 2,
  parameter int CTRL_SHIFT = 2,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_valid,
  input  logic [CH_W-1:0]      host_chan,
  input  logic                 host_win,
  input  logic [OFF_W-1:0]     host_off,
  input  logic [1:0]           host_size,
  input  logic                 host_we,
  input  logic [DW-1:0]        host_wdata,
  output logic                 host_rvalid,
  output logic [DW-1:0]        host_rdata,
  output logic [NUM_CH-1:0]    tf_stb,
  output logic                 tf_we,
  output logic [TF_AW-1:0]     tf_addr,
  output logic [1:0]           tf_size,
  output logic [DW-1:0]        tf_wdata,
  input  logic [NUM_CH*DW-1:0] tf_rdata
);
  tf_cmd_t cmd;

  ide_acc_qualify #(
    .OFF_W(OFF_W), .CTRL_OFF(CTRL_OFF), .CTRL_SHIFT(CTRL_SHIFT)
  ) u_qual (
    .win (host_win),
    .off (host_off),
    .size(acc_size_e'(host_size)),
    .cmd (cmd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_stb
    assign tf_stb[c] = host_valid && cmd.ok && (host_chan == CH_W'(c));
  end

  assign tf_we    = host_we;
  assign tf_addr  = cmd.addr;
  assign tf_size  = cmd.size;
  assign tf_wdata = host_wdata;

  ide_rd_return #(
    .NUM_CH(NUM_CH), .DW(DW), .CH_W(CH_W)
  ) u_ret (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (host_valid && !host_we),
    .ok      (cmd.ok),
    .size    (cmd.size),
    .chan    (host_chan),
    .tf_rdata(tf_rdata),
    .rvalid  (host_rvalid),
    .rdata   (host_rdata)
  );
endmodule

// File: rtl/ide_chan_decode_chk.sv
module ide_chan_decode_chk #(
  parameter int NUM_CH = 2,
  parameter int DW     = 32,
  parameter int OFF_W  = 3,
  parameter int CH_W   = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              host_valid,
  input logic              host_win,
  input logic [OFF_W-1:0]  host_off,
  input logic [1:0]        host_size,
  input logic              host_we,
  input logic              host_rvalid,
  input logic [DW-1:0]     host_rdata,
  input logic [NUM_CH-1:0] tf_stb,
  input logic [3:0]        tf_addr
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!host_rvalid && host_rdata == '0));

  a_r5_wide_at_zero: assert property (@(posedge clk) disable iff (rst)
    (tf_stb != '0 && !host_win && host_size != 2'd0) |-> host_off == '0);

  a_r6_ctrl_remap: assert property (@(posedge clk) disable iff (rst)
    (tf_stb != '0 && host_win) |-> (tf_addr == 4'hC && host_size == 2'd0));

  a_r8_reserved_dropped: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_size == 2'd3) |-> tf_stb == '0);

  a_r9_one_channel: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tf_stb));

  a_r10_read_valid: assert property (@(posedge clk) disable iff (rst)
    (host_valid && !host_we) |=> host_rvalid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(host_valid && !host_we) |=> !host_rvalid);
endmodule

bind ide_chan_decode ide_chan_decode_chk #(
  .NUM_CH(NUM_CH), .DW(DW), .OFF_W(OFF_W), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst(rst), .host_valid(host_valid), .host_win(host_win),
  .host_off(host_off), .host_size(host_size), .host_we(host_we),
  .host_rvalid(host_rvalid), .host_rdata(host_rdata),
  .tf_stb(tf_stb), .tf_addr(tf_addr)
);

// File: tb/ide_chan_decode_bench.sv
module ide_chan_decode_bench;
  localparam int NUM_CH = 2;
  localparam int DW     = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              host_valid = 1'b0;
  logic [0:0]        host_chan = '0;
  logic              host_win = 1'b0;
  logic [2:0]        host_off = '0;
  logic [1:0]        host_size = '0;
  logic              host_we = 1'b0;
  logic [DW-1:0]     host_wdata = '0;
  logic              host_rvalid;
  logic [DW-1:0]     host_rdata;
  logic [NUM_CH-1:0] tf_stb;
  logic              tf_we;
  logic [3:0]        tf_addr;
  logic [1:0]        tf_size;
  logic [DW-1:0]     tf_wdata;
  logic [NUM_CH*DW-1:0] tf_rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] stub_val(int c, logic [3:0] a);
    return {8'hA5 ^ 8'(c), 8'h3C, 4'(c), a, 4'hE, a};
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_stub
    assign tf_rdata[c*DW +: DW] = stub_val(c, tf_addr);
  end

  ide_chan_decode u_ide_chan_decode (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_chan(host_chan),
    .host_win(host_win), .host_off(host_off), .host_size(host_size),
    .host_we(host_we), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
    .host_rdata(host_rdata), .tf_stb(tf_stb), .tf_we(tf_we),
    .tf_addr(tf_addr), .tf_size(tf_size), .tf_wdata(tf_wdata),
    .tf_rdata(tf_rdata)
  );

  function automatic bit exp_ok(logic w, logic [2:0] o, logic [1:0] s);
    if (s == 2'd3) return 1'b0;
    if (!w) return (s == 2'd0) || (o == 3'd0);
    return (s == 2'd0) && (o[1:0] == 2'd2);
  endfunction

  function automatic logic [3:0] exp_addr(logic w, logic [2:0] o);
    return w ? 4'hC : {1'b0, o};
  endfunction

  function automatic logic [31:0] exp_mask(logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic string tag_of(logic w, logic [2:0] o, logic [1:0] s);
    if (s == 2'd3) return "R8";
    if (w) return exp_ok(w, o, s) ? "R6" : "R7";
    if (s == 2'd0) return "R2";
    if (o != 3'd0) return "R5";
    return (s == 2'd1) ? "R3" : "R4";
  endfunction

  task automatic chk(bit good, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(int c, logic w, logic [2:0] o, logic [1:0] s,
                        logic we, logic [31:0] wd);
    bit ok;
    logic [3:0] a;
    logic [31:0] er;
    logic [NUM_CH-1:0] es;
    string t;
    ok = exp_ok(w, o, s);
    a  = exp_addr(w, o);
    t  = tag_of(w, o, s);
    es = ok ? NUM_CH'(1 << c) : '0;
    host_valid = 1'b1; host_chan = 1'(c); host_win = w; host_off = o;
    host_size = s; host_we = we; host_wdata = wd;
    #1;
    chk(tf_stb == es, t, 32'(tf_stb), 32'(es));
    if (ok) begin
      chk(tf_addr == a && tf_size == s, t, {24'd0, tf_size, 2'd0, tf_addr},
          {24'd0, s, 2'd0, a});
      chk(tf_we == we && tf_wdata == wd, "R2", tf_wdata, wd);
      chk(tf_stb[c], "R9", 32'(tf_stb), 32'(es));
    end
    @(negedge clk);
    host_valid = 1'b0;
    chk(host_rvalid == !we, "R10", 32'(host_rvalid), 32'(!we));
    if (!we) begin
      er = ok ? (stub_val(c, a) & exp_mask(s)) : exp_mask(s);
      chk(host_rdata == er, t, host_rdata, er);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(host_rvalid == 1'b0 && host_rdata == '0, "R1", host_rdata, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(host_rvalid == 1'b0 && host_rdata == '0, "R1", host_rdata, 32'd0);
    // directed corner cases
    for (int o = 0; o < 8; o++) access(o % 2, 1'b0, 3'(o), 2'd0, 1'b0, 32'h0);
    access(0, 1'b0, 3'd0, 2'd1, 1'b0, 32'h0);      // R3
    access(1, 1'b0, 3'd0, 2'd2, 1'b0, 32'h0);      // R4
    access(0, 1'b0, 3'd2, 2'd1, 1'b0, 32'h0);      // R5 half float
    access(1, 1'b0, 3'd4, 2'd2, 1'b0, 32'h0);      // R5 word float
    access(0, 1'b0, 3'd6, 2'd2, 1'b1, 32'h1234);   // R5 write dropped
    access(1, 1'b1, 3'd2, 2'd0, 1'b0, 32'h0);      // R6 read
    access(0, 1'b1, 3'd2, 2'd0, 1'b1, 32'h0E);     // R6 write
    access(0, 1'b1, 3'd6, 2'd0, 1'b0, 32'h0);      // R6 bit 2 ignored
    access(1, 1'b1, 3'd0, 2'd0, 1'b0, 32'h0);      // R7
    access(0, 1'b1, 3'd2, 2'd1, 1'b0, 32'h0);      // R7 wide at offset 2
    access(1, 1'b1, 3'd0, 2'd2, 1'b1, 32'h55);     // R7 write dropped
    access(0, 1'b0, 3'd0, 2'd3, 1'b0, 32'h0);      // R8
    access(1, 1'b1, 3'd2, 2'd3, 1'b1, 32'h0);      // R8
    // constrained random mix
    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++) begin
      access(int'($urandom % NUM_CH), 1'($urandom), 3'($urandom),
             2'($urandom), 1'($urandom), $urandom);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule